// File: doc/BRIEF.md
# Three-Bank Interleaved Neighbour Address Generator

This block turns a lattice cell index and a neighbour selection into read addresses for a cell store that is split across three interleaved banks. A cell with linear index `t` lives in bank `t mod 3`, at word `t / 3` inside that bank. Because of this split, a group of neighbours that sit next to each other in the lattice map to addresses that are not consecutive within any one bank. When their residues differ, up to three of those neighbours can be fetched in the same cycle.

A request carries a base cell index, a mode bit and a 3-bit select. In single-direction mode the select picks one neighbour offset. In group mode it picks a fixed set of three offsets, called slots. Each offset is added to the base in its own adder, and the result wraps modulo the lattice size. The adder results then go to an arbiter that gives each bank to at most one slot per cycle, with the lowest slot number winning. A slot that loses is kept and issued in a later cycle. While such slots are waiting, `busy` is high and new requests are ignored.

Top module: `cell_agen3`

## Requirements
- R1: For a target cell index `t`, the word is presented on bank `t mod 3` with address `t / 3` and `bank_en` for that bank high. A request accepted at a clock edge shows its first words in the cycle after that edge.
- R2: When `req_mode`=0, only slot 0 is used (tag 0). `req_sel` gives its offset: 0→0, 1→+1, 2→-1, 3→+ROW, 4→-ROW, 5→+ROW+1, 6→-ROW-1, 7→+ROW-1.
- R3: When `req_mode`=1, `req_sel[1:0]` chooses the offsets for slots 0, 1 and 2. Group 0 is {0,+1,-1}. Group 1 is {0,+ROW,-ROW}. Group 2 is {+1,+ROW,-1}. Group 3 is {+1,+ROW,-(ROW+1)}.
- R4: The target index is `(base + offset) mod CELLS`. This applies in both directions, below 0 and at or above CELLS.
- R5: If several pending slots share a bank, the lowest slot is issued first. Each remaining slot goes out in a later cycle, and `busy` is high in every output cycle that still leaves slots to issue.
- R6: A request offered while `busy` is high is ignored and produces no output words.
- R7: While reset is high and on the cycle after it, all `bank_en` bits and `busy` are 0.
- R8: With no pending slots and no request, all `bank_en` bits are 0 in the next cycle.
- R9: Each active slot of a request is issued exactly once. The `bank_tag` field of a bank (2 bits at `[2b+1:2b]`) gives the slot number, and no two enabled banks in one cycle carry the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 0 = single direction, 1 = neighbour group |
| req_sel | input | 3 | Direction code or group code |
| req_base | input | IDX_W (21) | Base cell index, below CELLS |
| bank_en | output | 3 | Per-bank word valid |
| bank_addr | output | 3*ADDR_W (60) | Per-bank in-bank address, bank b at `[ADDR_W*b +: ADDR_W]` |
| bank_tag | output | 6 | Per-bank slot number |
| busy | output | 1 | Deferred slots remain; requests are ignored |

## Verification
The first words of an accepted request are due one edge after acceptance. Each deferred slot is due one edge later per earlier round. The cycle after the last round must show no enables and a low `busy`. The bench drives every input at a falling edge and checks all three banks at each following falling edge. For every round it works out the expected bank, address and tag from its own residue and wrap arithmetic. Requests that are held during `busy` are then shown to be ignored, because the idle cycle that follows carries no words.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int NBANK  = 3;
  localparam int NSLOT  = 3;
  localparam int SEL_W  = 3;
  localparam int TAG_W  = 2;
  localparam int BANK_W = 2;

  typedef enum logic {
    MODE_DIR = 1'b0,
    MODE_GRP = 1'b1
  } agen_mode_e;
endpackage

// File: rtl/agen_offset_rom.sv
module agen_offset_rom
  import agen_pkg::*;
#(
  parameter int IDX_W = 21,
  parameter int ROW   = 1000
) (
  input  logic                            mode,
  input  logic [SEL_W-1:0]                sel,
  output logic [NSLOT-1:0][IDX_W:0]       offs,
  output logic [NSLOT-1:0]                act
);
  localparam int OW = IDX_W + 1;

  function automatic logic [IDX_W:0] dir_off(input logic [SEL_W-1:0] d);
    case (d)
      3'd0:    return OW'(0);
      3'd1:    return OW'(1);
      3'd2:    return OW'(-1);
      3'd3:    return OW'(ROW);
      3'd4:    return OW'(-ROW);
      3'd5:    return OW'(ROW + 1);
      3'd6:    return OW'(-(ROW + 1));
      default: return OW'(ROW - 1);
    endcase
  endfunction

  always_comb begin
    offs = '0;
    act  = '0;
    if (agen_mode_e'(mode) == MODE_DIR) begin
      offs[0] = dir_off(sel);
      act     = 3'b001;
    end else begin
      act = 3'b111;
      case (sel[1:0])
        2'd0: begin
          offs[0] = OW'(0);  offs[1] = OW'(1);   offs[2] = OW'(-1);
        end
        2'd1: begin
          offs[0] = OW'(0);  offs[1] = OW'(ROW); offs[2] = OW'(-ROW);
        end
        2'd2: begin
          offs[0] = OW'(1);  offs[1] = OW'(ROW); offs[2] = OW'(-1);
        end
        default: begin
          offs[0] = OW'(1);  offs[1] = OW'(ROW); offs[2] = OW'(-(ROW + 1));
        end
      endcase
    end
  end
endmodule

// File: rtl/agen_wrap_adder.sv
module agen_wrap_adder
  import agen_pkg::*;
#(
  parameter int IDX_W  = 21,
  parameter int ADDR_W = 20,
  parameter int CELLS  = 2000000
) (
  input  logic [IDX_W-1:0]  base,
  input  logic [IDX_W:0]    off,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);
  localparam int SW = IDX_W + 2;
  localparam logic signed [SW-1:0] LIM = SW'(CELLS);

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] wrapped;
  logic [IDX_W-1:0]     tgt;

  always_comb begin
    sum = $signed({2'b00, base}) + $signed({off[IDX_W], off});
    if (sum < 0)
      wrapped = sum + LIM;
    else if (sum >= LIM)
      wrapped = sum - LIM;
    else
      wrapped = sum;
    tgt  = IDX_W'(wrapped);
    bank = BANK_W'(tgt % IDX_W'(NBANK));
    addr = ADDR_W'(tgt / IDX_W'(NBANK));
  end
endmodule

// File: rtl/agen_bank_arb.sv
module agen_bank_arb
  import agen_pkg::*;
(
  input  logic [NSLOT-1:0]              pend,
  input  logic [NSLOT-1:0][BANK_W-1:0]  bank,
  output logic [NSLOT-1:0]              grant
);
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      grant[s] = pend[s];
      for (int j = 0; j < s; j++) begin
        if (pend[j] && (bank[j] == bank[s]))
          grant[s] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cell_agen3.sv
module cell_agen3
  import agen_pkg::*;
#(
  parameter int IDX_W  = 21,
  parameter int ADDR_W = 20,
  parameter int CELLS  = 2000000,
  parameter int ROW    = 1000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_mode,
  input  logic [2:0]               req_sel,
  input  logic [IDX_W-1:0]         req_base,
  output logic [2:0]               bank_en,
  output logic [3*ADDR_W-1:0]      bank_addr,
  output logic [5:0]               bank_tag,
  output logic                     busy
);
  logic [NSLOT-1:0][IDX_W:0]       offs;
  logic [NSLOT-1:0]                rom_act;
  logic [NSLOT-1:0][BANK_W-1:0]    new_bank;
  logic [NSLOT-1:0][ADDR_W-1:0]    new_addr;

  logic [NSLOT-1:0][BANK_W-1:0]    held_bank;
  logic [NSLOT-1:0][ADDR_W-1:0]    held_addr;
  logic [NSLOT-1:0]                pend_q;

  logic                            accept;
  logic [NSLOT-1:0]                src_pend;
  logic [NSLOT-1:0][BANK_W-1:0]    src_bank;
  logic [NSLOT-1:0][ADDR_W-1:0]    src_addr;
  logic [NSLOT-1:0]                grant;

  logic [NBANK-1:0]                en_n;
  logic [NBANK-1:0][ADDR_W-1:0]    addr_n;
  logic [NBANK-1:0][TAG_W-1:0]     tag_n;

  agen_offset_rom #(.IDX_W(IDX_W), .ROW(ROW)) u_rom (
    .mode (req_mode),
    .sel  (req_sel),
    .offs (offs),
    .act  (rom_act)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_add
    agen_wrap_adder #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CELLS(CELLS)) u_add (
      .base (req_base),
      .off  (offs[s]),
      .bank (new_bank[s]),
      .addr (new_addr[s])
    );
  end

  assign accept   = req_valid && (pend_q == '0);
  assign src_pend = accept ? rom_act  : pend_q;
  assign src_bank = accept ? new_bank : held_bank;
  assign src_addr = accept ? new_addr : held_addr;

  agen_bank_arb u_arb (
    .pend  (src_pend),
    .bank  (src_bank),
    .grant (grant)
  );

  always_comb begin
    en_n   = '0;
    addr_n = '0;
    tag_n  = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (grant[s] && (src_bank[s] == BANK_W'(b))) begin
          en_n[b]   = 1'b1;
          addr_n[b] = src_addr[s];
          tag_n[b]  = TAG_W'(s);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      held_bank <= new_bank;
      held_addr <= new_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      bank_en   <= '0;
      bank_addr <= '0;
      bank_tag  <= '0;
    end else begin
      pend_q    <= src_pend & ~grant;
      bank_en   <= en_n;
      bank_addr <= addr_n;
      bank_tag  <= tag_n;
    end
  end

  assign busy = |pend_q;
endmodule

// File: rtl/agen3_checker.sv
module agen3_checker #(
  parameter int ADDR_W = 20,
  parameter int CELLS  = 2000000
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [2:0]          bank_en,
  input logic [3*ADDR_W-1:0] bank_addr,
  input logic [5:0]          bank_tag,
  input logic                busy
);
  localparam int BANK_ROWS = (CELLS + 2) / 3;

  assert_reset_idle_R7: assert property (@(posedge clk)
    $past(rst) |-> (bank_en == 3'b000 && !busy));

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (bank_en != 3'b000));

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (rst)
    (!bank_en[0] || bank_addr[0*ADDR_W +: ADDR_W] < ADDR_W'(BANK_ROWS)) &&
    (!bank_en[1] || bank_addr[1*ADDR_W +: ADDR_W] < ADDR_W'(BANK_ROWS)) &&
    (!bank_en[2] || bank_addr[2*ADDR_W +: ADDR_W] < ADDR_W'(BANK_ROWS)));

  assert_deferred_issue_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (bank_en != 3'b000));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> (bank_en == 3'b000));

  assert_tag_unique_R9: assert property (@(posedge clk) disable iff (rst)
    (!(bank_en[0] && bank_en[1]) || bank_tag[1:0] != bank_tag[3:2]) &&
    (!(bank_en[0] && bank_en[2]) || bank_tag[1:0] != bank_tag[5:4]) &&
    (!(bank_en[1] && bank_en[2]) || bank_tag[3:2] != bank_tag[5:4]));
endmodule

bind cell_agen3 agen3_checker #(.ADDR_W(ADDR_W), .CELLS(CELLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .bank_en   (bank_en),
  .bank_addr (bank_addr),
  .bank_tag  (bank_tag),
  .busy      (busy)
);

// File: tb/sim_cell_agen3.sv
module sim_cell_agen3;
  localparam int IDX_W  = 21;
  localparam int ADDR_W = 20;
  localparam int CELLS  = 2000000;
  localparam int ROW    = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_mode = 1'b0;
  logic [2:0] req_sel = '0;
  logic [IDX_W-1:0] req_base = '0;
  logic [2:0] bank_en;
  logic [3*ADDR_W-1:0] bank_addr;
  logic [5:0] bank_tag;
  logic busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cell_agen3 #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CELLS(CELLS), .ROW(ROW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_sel(req_sel), .req_base(req_base), .bank_en(bank_en),
    .bank_addr(bank_addr), .bank_tag(bank_tag), .busy(busy)
  );

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int offset_of(input bit mode, input int sel, input int slot);
    int g [4][3];
    if (!mode) begin
      case (sel)
        0: return 0;
        1: return 1;
        2: return -1;
        3: return ROW;
        4: return -ROW;
        5: return ROW + 1;
        6: return -(ROW + 1);
        default: return ROW - 1;
      endcase
    end
    g[0] = '{0, 1, -1};
    g[1] = '{0, ROW, -ROW};
    g[2] = '{1, ROW, -1};
    g[3] = '{1, ROW, -(ROW + 1)};
    return g[sel % 4][slot];
  endfunction

  task automatic check_idle(input string rq);
    check(rq, "bank_en idle", longint'(bank_en), 0);
    check(rq, "busy idle", longint'(busy), 0);
  endtask

  // Issue one request and check every round of output words plus the idle cycle after.
  task automatic run_req(input bit mode, input int sel, input int base, input bit hold, input string rq);
    int tgt [3];
    int bk [3];
    bit pend [3];
    int nslot;
    bit any;
    nslot = mode ? 3 : 1;
    for (int s = 0; s < 3; s++) begin
      tgt[s] = (((base + offset_of(mode, sel, s)) % CELLS) + CELLS) % CELLS;
      bk[s] = tgt[s] % 3;
      pend[s] = (s < nslot);
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_mode = mode;
    req_sel = 3'(sel);
    req_base = IDX_W'(base);
    do begin
      @(negedge clk);
      for (int b = 0; b < 3; b++) begin
        int win;
        win = -1;
        for (int s = 2; s >= 0; s--)
          if (pend[s] && bk[s] == b) win = s;
        if (win < 0) begin
          check(rq, $sformatf("bank%0d en", b), longint'(bank_en[b]), 0);
        end else begin
          check(rq, $sformatf("bank%0d en", b), longint'(bank_en[b]), 1);
          check(rq, $sformatf("bank%0d addr", b), longint'(bank_addr[b*ADDR_W +: ADDR_W]), tgt[win] / 3);
          check(rq, $sformatf("bank%0d tag", b), longint'(bank_tag[2*b +: 2]), win);
          pend[win] = 0;
        end
      end
      any = pend[0] | pend[1] | pend[2];
      check(rq, "busy", longint'(busy), longint'(any));
      req_valid = hold && any;
      req_base = IDX_W'((base + 7) % CELLS);
    end while (any);
    req_valid = 1'b0;
    @(negedge clk);
    check_idle(rq);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check_idle("R7 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R7 after reset");
    @(negedge clk);
    check_idle("R8 no request");
  endtask

  task automatic t_single_dirs;
    for (int d = 0; d < 8; d++) run_req(1'b0, d, 500500, 1'b0, "R1 R2 single");
  endtask

  task automatic t_groups_clean;
    run_req(1'b1, 0, 123456, 1'b0, "R3 group0");
    run_req(1'b1, 1, 777777, 1'b0, "R3 group1");
  endtask

  task automatic t_conflicts;
    run_req(1'b1, 2, 300000, 1'b0, "R5 R9 group2 pair");
    run_req(1'b1, 3, 300001, 1'b0, "R5 R9 group3 triple");
  endtask

  task automatic t_hold_busy;
    run_req(1'b1, 3, 42042, 1'b1, "R6 held during busy");
  endtask

  task automatic t_wrap;
    run_req(1'b1, 1, 0, 1'b0, "R4 wrap low");
    run_req(1'b0, 1, CELLS - 1, 1'b0, "R4 wrap high");
    run_req(1'b1, 3, CELLS - 1, 1'b0, "R4 wrap group3");
    run_req(1'b0, 6, 500, 1'b0, "R4 wrap diag");
  endtask

  initial begin
    t_reset();
    t_single_dirs();
    t_groups_clean();
    t_conflicts();
    t_hold_busy();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule